// File: doc/BRIEF.md
# DMA Page Register Address Extender

This block widens the 16-bit transfer address of a four-channel DMA controller to a 20-bit, 1 MB memory address. The CPU writes 4-bit page values into write-only registers at three I/O offsets. While a DMA channel is acknowledged, the block takes the page that belongs to that channel and places it on address bits 19:16. The controller's own 16-bit address supplies bits 15:0.

Channels 0 and 1 share a single page register. Pages are static. When the low 16-bit address rolls over, a transfer wraps inside its own 64 KB page and does not carry into the page.

Channel 0 serves memory refresh and runs four-clock bus cycles. Channels 1 to 3 run five-clock cycles, so the block raises a cycle-extend request whenever one of those channels owns the bus. The DMA core, the arbitration logic and the memory are outside this block.

Top module: `dma_page_ext`

## Requirements
- R1: Offset selects the register: a write at offset 1 loads the channel 2 page, offset 2 loads the channel 3 page, and offset 3 loads the single page used by both channel 0 and channel 1. A write at offset 0 changes no page.
- R2: Write data bit 0 becomes address bit 16, bit 1 becomes bit 17, bit 2 becomes bit 18 and bit 3 becomes bit 19. Data bits 7:4 have no effect on any page.
- R3: While a channel is acknowledged, `mem_addr_o[15:0]` equals `dma_addr_i`. Bits 19:16 hold the page unchanged for every low address, including 16'hFFFF and 16'h0000, so the address never carries into the page.
- R4: With no acknowledge active, `mem_addr_o` is 0, `addr_oe_o` is 0 and `cycle_ext_o` is 0.
- R5: `cycle_ext_o` is 1 while the selected channel is 1, 2 or 3. It is 0 while the selected channel is 0.
- R6: After reset every page is 0, so a grant on any channel before any write gives address bits 19:16 equal to 0.
- R7: When several acknowledges are active at once, the lowest-numbered active channel supplies both the page and the cycle-extend decision.
- R8: A write takes effect at the clock edge on which the write strobe is sampled. Outside writes the pages hold their values.
- R9: A write during an active grant changes bits 19:16 from the next clock on. Before that edge the output shows the old page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DMA clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | CPU I/O write strobe for the page block |
| io_ofs_i | input | 2 | I/O offset within the page block |
| io_data_i | input | 8 | CPU write data |
| dack_i | input | 4 | Per-channel DMA acknowledge, active high |
| dma_addr_i | input | 16 | Low address from the DMA controller |
| mem_addr_o | output | 20 | Extended memory address |
| addr_oe_o | output | 1 | Address drive enable, high during a grant |
| cycle_ext_o | output | 1 | Request for one extra wait clock |

## Verification
On every cycle, the assertions check four things:
- the block stays quiet with no grant;
- the low address passes through unchanged;
- the cycle extension follows the lowest active channel;
- the pages stay stable outside writes and on offset-0 writes.

The reset value of the pages, the offset-to-channel mapping, the masking of data bits 7:4, the wrap at 16'hFFFF and the exact edge at which a write made during a grant becomes visible all need a history of earlier writes. Only the bench's scenarios show those, compared against its own page model.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int SHARED_OFS = 3;  // channels 0 and 1 share this offset

  // channel -> register offset: ch0,ch1 -> 3, ch2 -> 1, ch3 -> 2
  function automatic int ch_to_ofs(input int ch);
    if (ch < 2) return SHARED_OFS;
    else return ch - 1;
  endfunction
endpackage

// File: rtl/dma_pg_regs.sv
module dma_pg_regs #(
  parameter int OFS_W  = 2,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  localparam int NUM_OFS = 1 << OFS_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [OFS_W-1:0]                  ofs_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [NUM_OFS-1:0][PAGE_W-1:0]    page_o
);
  assign page_o[0] = '0;  // offset 0 holds no register

  for (genvar g = 1; g < NUM_OFS; g++) begin : g_pg
    logic [PAGE_W-1:0] pg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pg_q <= '0;
      else if (wr_i && ofs_i == OFS_W'(g))  pg_q <= data_i[PAGE_W-1:0];
    end
    assign page_o[g] = pg_q;
  end
endmodule

// File: rtl/dma_pg_chan_sel.sv
module dma_pg_chan_sel #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] ack_i,
  output logic              any_o,
  output logic [CH_W-1:0]   ch_o
);
  // scan downward so the lowest active channel is the last assignment
  always_comb begin
    ch_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ack_i[i]) ch_o = CH_W'(i);
    end
  end
  assign any_o = |ack_i;
endmodule

// File: rtl/dma_pg_wait.sv
module dma_pg_wait #(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] WAIT_MASK = 4'b1110,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            any_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            ext_o
);
  assign ext_o = any_i & WAIT_MASK[ch_i];
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
  import dma_pg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter int LOW_W  = 16,
  parameter logic [NUM_CH-1:0] WAIT_MASK = 4'b1110,
  localparam int NUM_OFS = 1 << OFS_W,
  localparam int ADDR_W  = LOW_W + PAGE_W,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic [OFS_W-1:0]  io_ofs_i,
  input  logic [DATA_W-1:0] io_data_i,
  input  logic [NUM_CH-1:0] dack_i,
  input  logic [LOW_W-1:0]  dma_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              addr_oe_o,
  output logic              cycle_ext_o
);
  logic [NUM_OFS-1:0][PAGE_W-1:0] page_q;
  logic                           any_ack;
  logic [CH_W-1:0]                sel_ch;
  logic [NUM_CH-1:0][OFS_W-1:0]   ch_ofs;
  logic [PAGE_W-1:0]              sel_page;

  dma_pg_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(io_wr_i),
    .ofs_i(io_ofs_i), .data_i(io_data_i), .page_o(page_q)
  );

  dma_pg_chan_sel #(.NUM_CH(NUM_CH)) u_sel (
    .ack_i(dack_i), .any_o(any_ack), .ch_o(sel_ch)
  );

  dma_pg_wait #(.NUM_CH(NUM_CH), .WAIT_MASK(WAIT_MASK)) u_wait (
    .any_i(any_ack), .ch_i(sel_ch), .ext_o(cycle_ext_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    assign ch_ofs[c] = OFS_W'(ch_to_ofs(c));
  end

  assign sel_page   = page_q[ch_ofs[sel_ch]];
  assign addr_oe_o  = any_ack;
  // page is concatenated, never summed: low rollover stays in page
  assign mem_addr_o = any_ack ? {sel_page, dma_addr_i} : '0;
endmodule

// File: rtl/dma_page_ext_chk.sv
module dma_page_ext_chk #(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 2,
  parameter int PAGE_W = 4,
  parameter int LOW_W  = 16,
  localparam int NUM_OFS = 1 << OFS_W,
  localparam int ADDR_W  = LOW_W + PAGE_W
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           io_wr_i,
  input logic [OFS_W-1:0]               io_ofs_i,
  input logic [NUM_CH-1:0]              dack_i,
  input logic [LOW_W-1:0]               dma_addr_i,
  input logic [ADDR_W-1:0]              mem_addr_o,
  input logic                           addr_oe_o,
  input logic                           cycle_ext_o,
  input logic [NUM_OFS-1:0][PAGE_W-1:0] page_q
);
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_i == '0) |-> (mem_addr_o == '0 && !addr_oe_o && !cycle_ext_o));

  a_r3_low_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o |-> (mem_addr_o[LOW_W-1:0] == dma_addr_i));

  a_r5_ch0_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_i[0] |-> !cycle_ext_o);

  a_r7_upper_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_i != '0 && !dack_i[0]) |-> cycle_ext_o);

  a_r1_shared_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_i[1:0] != 2'b00) |-> (mem_addr_o[ADDR_W-1:LOW_W] == page_q[NUM_OFS-1]));

  a_r8_pages_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(page_q));

  a_r1_ofs0_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_ofs_i == '0) |=> $stable(page_q));
endmodule

bind dma_page_ext dma_page_ext_chk #(
  .NUM_CH(NUM_CH), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .LOW_W(LOW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_wr_i(io_wr_i), .io_ofs_i(io_ofs_i),
  .dack_i(dack_i), .dma_addr_i(dma_addr_i), .mem_addr_o(mem_addr_o),
  .addr_oe_o(addr_oe_o), .cycle_ext_o(cycle_ext_o), .page_q(page_q)
);

// File: tb/dma_page_ext_test.sv
module dma_page_ext_test;
  localparam time CLK_PERIOD = 250ns;

  typedef struct {
    string       tag;
    logic [19:0] addr;
    logic        oe;
    logic        ext;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        io_wr = 0;
  logic [1:0]  io_ofs = '0;
  logic [7:0]  io_data = '0;
  logic [3:0]  dack = '0;
  logic [15:0] dma_addr = '0;
  logic [19:0] mem_addr;
  logic        addr_oe, cycle_ext;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb[$];
  logic [3:0] model_pg [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_ext uut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_ofs_i(io_ofs),
    .io_data_i(io_data), .dack_i(dack), .dma_addr_i(dma_addr),
    .mem_addr_o(mem_addr), .addr_oe_o(addr_oe), .cycle_ext_o(cycle_ext)
  );

  function automatic logic [3:0] exp_page(input logic [3:0] a);
    for (int c = 0; c < 4; c++)
      if (a[c]) return model_pg[(c < 2) ? 3 : c - 1];
    return 4'h0;
  endfunction

  function automatic logic exp_ext(input logic [3:0] a);
    return (a != 4'b0) && !a[0];
  endfunction

  // driver: one grant cycle, expectation pushed to scoreboard
  task automatic drive(input string tag, input logic [3:0] a, input logic [15:0] lo);
    exp_t e;
    @(posedge clk) #1;
    io_wr = 0; dack = a; dma_addr = lo;
    e.tag = tag; e.oe = (a != 0); e.ext = exp_ext(a);
    e.addr = (a != 0) ? {exp_page(a), lo} : 20'h0;
    sb.push_back(e);
  endtask

  task automatic wr_page(input logic [1:0] ofs, input logic [7:0] d);
    @(posedge clk) #1;
    dack = '0; io_wr = 1; io_ofs = ofs; io_data = d;
    @(posedge clk) #1;
    io_wr = 0;
    if (ofs != 0) model_pg[ofs] = d[3:0];
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (mem_addr !== e.addr || addr_oe !== e.oe || cycle_ext !== e.ext) begin
        n_fail++;
        $display("FAIL %s: got addr=%05h oe=%b ext=%b exp addr=%05h oe=%b ext=%b",
                 e.tag, mem_addr, addr_oe, cycle_ext, e.addr, e.oe, e.ext);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model_pg[i] = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R6 reset pages zero, R4 idle
    drive("R4 idle after reset", 4'b0000, 16'hBEEF);
    drive("R6 ch2 reset page", 4'b0100, 16'h1234);
    drive("R6 ch0 reset page", 4'b0001, 16'h5678);
    // R1 mapping
    wr_page(2'd1, 8'h05);
    wr_page(2'd2, 8'h0A);
    wr_page(2'd3, 8'h0C);
    drive("R1 ch2 from offset1", 4'b0100, 16'h0001);
    drive("R1 ch3 from offset2", 4'b1000, 16'h0002);
    drive("R1 ch0 from offset3", 4'b0001, 16'h0003);
    drive("R1 ch1 shares offset3", 4'b0010, 16'h0004);
    // R1 offset 0 ignored
    wr_page(2'd0, 8'h0F);
    drive("R1 ofs0 ch2 kept", 4'b0100, 16'h0010);
    drive("R1 ofs0 ch3 kept", 4'b1000, 16'h0011);
    drive("R1 ofs0 ch0 kept", 4'b0001, 16'h0012);
    // R2 bits and high nibble masking
    wr_page(2'd1, 8'hF9);
    drive("R2 high bits dropped", 4'b0100, 16'h00AA);
    wr_page(2'd2, 8'h31);
    drive("R2 bit0 to A16", 4'b1000, 16'h00BB);
    // R3 wrap within page
    drive("R3 top of page", 4'b1000, 16'hFFFF);
    drive("R3 wrap stays in page", 4'b1000, 16'h0000);
    // R5 wait
    drive("R5 ch0 no extend", 4'b0001, 16'h4000);
    drive("R5 ch1 extend", 4'b0010, 16'h4001);
    drive("R5 ch3 extend", 4'b1000, 16'h4002);
    // R7 priority
    drive("R7 ch0 over ch3", 4'b1001, 16'h7000);
    drive("R7 ch2 over ch3", 4'b1100, 16'h7001);
    drive("R7 ch1 over ch2", 4'b0110, 16'h7002);
    drive("R4 idle again", 4'b0000, 16'h7003);
    // R8/R9 write during grant: old page before edge, new after
    begin
      exp_t e;
      @(posedge clk) #1;
      dack = 4'b0100; dma_addr = 16'h2222;
      io_wr = 1; io_ofs = 2'd1; io_data = 8'h07;
      e.tag = "R9 old page before edge"; e.oe = 1; e.ext = 1;
      e.addr = {model_pg[1], 16'h2222};
      sb.push_back(e);
      model_pg[1] = 4'h7;
      @(posedge clk) #1;
      io_wr = 0;
      e.tag = "R9 new page after edge"; e.addr = {4'h7, 16'h2222};
      sb.push_back(e);
    end
    drive("R8 page holds", 4'b0100, 16'h2223);
    drive("R8 other pages hold", 4'b0010, 16'h2224);
    drive("R4 final idle", 4'b0000, 16'h0000);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule